// File: doc/BRIEF.md
# Multi-Width Configuration Data Serializer

This block takes configuration bytes that have already been decompressed and puts them onto one 8-bit data bus, together with a configuration clock (`dclk`) for the targets being loaded. It accepts bytes through a valid/ready handshake. It collects one group of bytes and then sends that group, and while a group is being sent it takes no new input. The DCLK rate comes from a programmable divider of the system clock.

The run-time mode sets how the bus is used:

- **One chain.** A single passive-serial chain is driven on line 0.
- **Two, four or eight chains.** That many passive-serial chains are driven at once, one data line per chain. The input bytes are interleaved across the chains, so byte k of a group belongs to chain k. Each line shifts out its own byte LSB first over eight DCLK cycles.
- **Byte-wide parallel.** A single target receives a whole byte on every DCLK cycle.

Timing towards the targets works as follows. Data changes only at a DCLK falling edge, so it is stable when a target captures on the rising edge. When there is no group to send, DCLK stays low and the bus is driven to zero.

Top module: `cfg_serializer`

## Requirements
- R1: After reset, `dclk` is 0, `dout` is 0, and both `in_ready` and `idle` are 1.
- R2: `cfg_mode` encoding:
  - 0 selects one chain, 1 selects two chains, 2 selects four chains, and 3 selects eight chains.
  - Any value with bit 2 set (4 to 7) selects byte-wide parallel mode.
- R3: A group holds n bytes in an n-chain mode and one byte in parallel mode. Once the last byte of a group is accepted, `in_ready` is 0 until the group has been sent.
- R4: In chain modes, byte k of a group drives data line k. Each line presents its byte LSB first, one bit per DCLK cycle, so a group takes exactly 8 DCLK rising edges.
- R5: In parallel mode, each group takes exactly one DCLK rising edge. All of `dout[7:0]` carries the byte, with bit i on line i.
- R6: In an n-chain mode, data lines n to 7 stay 0 throughout the transfer.
- R7: While a group is sent, DCLK is low for `cfg_div`+1 system clocks and then high for `cfg_div`+1 system clocks. The period is therefore 2×(`cfg_div`+1).
- R8: `dout` changes only in the same cycle as a DCLK falling edge or while DCLK is low. It is stable during every high phase. The first bit of a group is valid before the first rising edge.
- R9: When no group is being sent (including while input bytes are missing partway through a group), `dclk` is held at 0 and `dout` is 0.
- R10: `cfg_mode` and `cfg_div` are sampled when the first byte of a group is accepted. Changes after that point do not affect the group.
- R11: `in_ready` is 1 exactly when the block is collecting. `idle` is 1 only when it is collecting and no bytes of a partial group are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Bus mode (see R2) |
| cfg_div | input | DIV_W | DCLK half-period minus one, in system clocks |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| idle | output | 1 | Nothing held and nothing being sent |
| dclk | output | 1 | Configuration clock to the targets |
| dout | output | 8 | Configuration data lines |

## Verification
The assertions check four things on every cycle:
- the data bus holds its value through each DCLK high phase;
- the unused lines stay at zero in chain modes;
- DCLK and the bus are quiet whenever no group is being sent;
- the phase counter never passes the latched divider, and the latched settings stay frozen during a transfer.

The bench scenarios are what show the rest. They cover the actual bit order on each line, the interleaving of bytes across chains, the exact DCLK period for several divider values, and parallel mode. They also cover that a configuration change made partway through a group is ignored until the next group, and that a stall partway through a group keeps DCLK stopped.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_LANES = 8;
  localparam int unsigned MODE_W    = 3;

  typedef enum logic {S_COLLECT = 1'b0, S_SEND = 1'b1} ser_state_e;

  // Parallel mode when bit 2 of the mode is set.
  function automatic logic is_par(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  // Number of chains driven in a chain mode: 1, 2, 4 or 8.
  function automatic logic [3:0] lanes_of(input logic [MODE_W-1:0] m);
    if (m[2]) return 4'd1;
    return 4'd1 << m[1:0];
  endfunction

  // Index of the last byte in a group.
  function automatic logic [2:0] group_last(input logic [MODE_W-1:0] m);
    logic [3:0] n;
    n = lanes_of(m) - 4'd1;
    return n[2:0];
  endfunction

  // Index of the last DCLK beat in a group.
  function automatic logic [2:0] beat_last(input logic [MODE_W-1:0] m);
    return m[2] ? 3'd0 : 3'd7;
  endfunction

  // Lines that may carry data in the given mode.
  function automatic logic [MAX_LANES-1:0] lane_mask(input logic [MODE_W-1:0] m);
    logic [MAX_LANES-1:0] mk;
    for (int l = 0; l < int'(MAX_LANES); l++)
      mk[l] = m[2] || (4'(l) < lanes_of(m));
    return mk;
  endfunction
endpackage

// File: rtl/cfg_ser_clkgen.sv
module cfg_ser_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             dclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] hcnt;
  logic             phase_end;

  assign phase_end = (hcnt == div);
  assign fall_evt  = run && dclk && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      dclk <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      dclk <= 1'b0;
    end else if (phase_end) begin
      hcnt <= '0;
      dclk <= ~dclk;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R7
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt <= div));

  // R9
  rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $past(run));
endmodule

// File: rtl/cfg_ser_lanes.sv
module cfg_ser_lanes
  import cfg_ser_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES,
  localparam int unsigned SLOT_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              shift,
  input  logic              sending,
  input  logic [MODE_W-1:0] mode,
  output logic [LANES-1:0]  dout
);
  logic [BYTE_W-1:0] sh [LANES];
  logic [LANES-1:0]  mask;

  assign mask = lane_mask(mode);

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh[l] <= '0;
      else if (load && slot == SLOT_W'(l))
        sh[l] <= in_data;
      else if (shift)
        sh[l] <= sh[l] >> 1;
    end

    always_comb begin
      if (!sending)
        dout[l] = 1'b0;
      else if (is_par(mode))
        dout[l] = sh[0][l];
      else
        dout[l] = mask[l] & sh[l][0];
    end
  end

  // R6
  unused_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !is_par(mode)) |-> ((dout & ~mask) == '0));
endmodule

// File: rtl/cfg_ser_ctrl.sv
module cfg_ser_ctrl
  import cfg_ser_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LANES = MAX_LANES,
  localparam int unsigned SLOT_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              in_valid,
  input  logic              fall_evt,
  output logic              in_ready,
  output logic              idle,
  output logic              accept,
  output logic              sending,
  output logic [SLOT_W-1:0] slot,
  output logic [MODE_W-1:0] mode_q,
  output logic [DIV_W-1:0]  div_q
);
  ser_state_e        state;
  logic [2:0]        beat;
  logic [MODE_W-1:0] eff_mode;
  logic              group_full;

  assign in_ready   = (state == S_COLLECT);
  assign sending    = (state == S_SEND);
  assign idle       = in_ready && (slot == '0);
  assign accept     = in_valid && in_ready;
  assign eff_mode   = (slot == '0) ? cfg_mode : mode_q;
  assign group_full = (slot == SLOT_W'(group_last(eff_mode)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_COLLECT;
      slot   <= '0;
      beat   <= '0;
      mode_q <= '0;
      div_q  <= '0;
    end else begin
      case (state)
        S_COLLECT: if (accept) begin
          if (slot == '0) begin
            mode_q <= cfg_mode;
            div_q  <= cfg_div;
          end
          if (group_full) begin
            state <= S_SEND;
            slot  <= '0;
            beat  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        S_SEND: if (fall_evt) begin
          if (beat == beat_last(mode_q)) state <= S_COLLECT;
          else                           beat  <= beat + 1'b1;
        end
        default: state <= S_COLLECT;
      endcase
    end
  end

  // R3
  group_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && group_full) |=> !in_ready);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && $past(sending)) |-> ($stable(mode_q) && $stable(div_q)));

  // R11
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> in_ready);
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
  import cfg_ser_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  localparam int unsigned LANES = MAX_LANES,
  localparam int unsigned SLOT_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              idle,
  output logic              dclk,
  output logic [LANES-1:0]  dout
);
  logic              accept;
  logic              sending;
  logic              fall_evt;
  logic [SLOT_W-1:0] slot;
  logic [MODE_W-1:0] mode_q;
  logic [DIV_W-1:0]  div_q;

  cfg_ser_ctrl #(.DIV_W(DIV_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .cfg_div  (cfg_div),
    .in_valid (in_valid),
    .fall_evt (fall_evt),
    .in_ready (in_ready),
    .idle     (idle),
    .accept   (accept),
    .sending  (sending),
    .slot     (slot),
    .mode_q   (mode_q),
    .div_q    (div_q)
  );

  cfg_ser_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sending),
    .div      (div_q),
    .dclk     (dclk),
    .fall_evt (fall_evt)
  );

  cfg_ser_lanes #(.LANES(LANES)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .slot    (slot),
    .in_data (in_data),
    .shift   (fall_evt),
    .sending (sending),
    .mode    (mode_q),
    .dout    (dout)
  );

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(dout));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sending |-> (!dclk && dout == '0));

  // R8
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !dclk);
endmodule

// File: tb/cfg_serializer_bench.sv
`timescale 1ns/1ps
module cfg_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [7:0] cfg_div = 8'd0;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_ready, idle, dclk;
  logic [7:0] dout;

  always #5 clk = ~clk;

  cfg_serializer u_cfg_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .idle(idle), .dclk(dclk), .dout(dout)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: DCLK rises, captured data, high-phase length, period.
  logic       mon_clr = 1'b0;
  logic [7:0] cap [16];
  int cap_n, cyc, last_rise, hi_run, hi_min, hi_max, per_min, per_max;
  bit prev_d, have_rise;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      cap_n = 0; have_rise = 0; hi_run = 0;
      hi_min = 1 << 20; hi_max = 0; per_min = 1 << 20; per_max = 0;
    end
    if (dclk && !prev_d) begin
      if (cap_n < 16) cap[cap_n] = dout;
      cap_n++;
      if (have_rise) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc; have_rise = 1; hi_run = 1;
    end else if (dclk) begin
      hi_run++;
    end
    if (!dclk && prev_d) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
    end
    prev_d = dclk;
  end

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 4000 && !idle; t++) @(negedge clk);
    @(negedge clk);
  endtask

  // Expected data for each beat.
  function automatic logic [7:0] exp_beat(input logic [2:0] m, input logic [7:0] g [8], input int i);
    logic [7:0] v;
    int n;
    if (m[2]) return g[0];
    n = 1 << m[1:0];
    v = 8'h00;
    for (int l = 0; l < n; l++) v[l] = g[l][i];
    return v;
  endfunction

  task automatic check_group(input logic [2:0] m, input logic [7:0] d, input logic [7:0] g [8], input string tag);
    int beats;
    beats = m[2] ? 1 : 8;
    check(cap_n == beats, {tag, " R4/R5 rise count"}, cap_n, beats);
    for (int i = 0; i < beats && i < cap_n; i++)
      check(cap[i] == exp_beat(m, g, i), {tag, m[2] ? " R5 byte" : " R4 bit order"},
            cap[i], exp_beat(m, g, i));
    check(hi_min == int'(d) + 1 && hi_max == int'(d) + 1, {tag, " R7 high phase"}, hi_max, d + 1);
    if (!m[2])
      check(per_min == 2 * (int'(d) + 1) && per_max == 2 * (int'(d) + 1),
            {tag, " R7 period"}, per_max, 2 * (d + 1));
    check(dclk == 1'b0 && dout == 8'h00, {tag, " R9 quiet after group"}, {dclk, dout}, 0);
  endtask

  // Vectors: {mode, div, seed}.
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'd0, 8'hA5}, {3'd1, 8'd1, 8'h3C}, {3'd2, 8'd0, 8'h96},
    {3'd3, 8'd2, 8'h5A}, {3'd4, 8'd0, 8'hC3}, {3'd7, 8'd3, 8'h81},
    {3'd3, 8'd0, 8'hE7}, {3'd2, 8'd3, 8'h1F}
  };

  initial begin
    #1000000;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g [8];
    int nb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dclk == 0 && dout == 0, "R1 reset outputs", {dclk, dout}, 0);
    check(in_ready && idle, "R1 reset ready/idle", {in_ready, idle}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < 8; v++) begin
      logic [2:0] m;
      logic [7:0] d;
      m = VEC[v][18:16];
      d = VEC[v][15:8];
      nb = m[2] ? 1 : (1 << m[1:0]);
      for (int k = 0; k < 8; k++) g[k] = VEC[v][7:0] + 8'(k * 8'h4D);
      cfg_mode = m;
      cfg_div = d;
      clear_mon();
      for (int k = 0; k < nb; k++) begin
        send_byte(g[k]);
        if (k == nb - 1)
          check(!in_ready && !idle, "R3 ready low after group", {in_ready, idle}, 0);
        else
          check(in_ready && !idle, "R11 ready while collecting", {in_ready, idle}, 2);
      end
      wait_idle();
      check_group(m, d, g, $sformatf("vec%0d", v));
    end

    // R10: config changed after the first byte is ignored for this group
    for (int k = 0; k < 8; k++) g[k] = 8'h11 * 8'(k + 1);
    cfg_mode = 3'd3;
    cfg_div = 8'd0;
    clear_mon();
    send_byte(g[0]);
    cfg_mode = 3'd0;
    cfg_div = 8'd5;
    for (int k = 1; k < 8; k++) send_byte(g[k]);
    wait_idle();
    check_group(3'd3, 8'd0, g, "R10 mid-group change");

    // R9: stall partway through a two-chain group
    cfg_mode = 3'd1;
    cfg_div = 8'd1;
    g[0] = 8'hF0; g[1] = 8'h0F;
    clear_mon();
    send_byte(g[0]);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (dclk || dout != 0) quiet = 1'b0;
      end
      check(quiet, "R9 stall keeps dclk low", {dclk, dout}, 0);
      check(in_ready && !idle, "R11 partial group not idle", {in_ready, idle}, 2);
    end
    send_byte(g[1]);
    wait_idle();
    check_group(3'd1, 8'd1, g, "R9 after stall");

    // R9: empty input keeps DCLK stopped
    begin
      int rises;
      rises = cap_n;
      repeat (30) @(negedge clk);
      check(cap_n == rises && dclk == 0, "R9 no dclk when empty", cap_n, rises);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule